// File: doc/BRIEF.md
# SDRAM Power-Up and Self-Refresh Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state, then moves it into and out of self-refresh when a host asks. It divides the system clock to make the SDRAM clock. It holds clock-enable low through a first wait, then raises it and waits a second, longer time. After that it issues a fixed command train: precharge of every bank, a run of auto-refresh commands, and a mode-register load. It then leaves a few idle cycles and raises a sticky done flag.

Once the device is ready, a sleep request issues an auto-refresh command and drops clock-enable in the same SDRAM cycle, which enters self-refresh. A wake request raises clock-enable again while the bus shows command inhibit. The bus holds inhibit for a fixed number of SDRAM cycles before the block reports ready. The block does not cover read/write traffic or periodic refresh scheduling.

Every command is held for exactly one SDRAM clock period. The controller state changes only on the system edge where the SDRAM clock falls, so all bus outputs are steady around each rising SDRAM edge. The state machine has the states PWR_LOW, PWR_HIGH, PRE_ALL, AREF_RUN, LOAD_MODE, SETTLE, READY, SR_ENTER, SR_HOLD and SR_EXIT. Its transitions are:

- PWR_LOW→PWR_HIGH when the low wait ends.
- PWR_HIGH→PRE_ALL when the high wait ends.
- PRE_ALL→AREF_RUN after one cycle.
- AREF_RUN→LOAD_MODE after the last refresh.
- LOAD_MODE→SETTLE after one cycle.
- SETTLE→READY when the settle count ends.
- READY→SR_ENTER on a sleep request.
- SR_ENTER→SR_HOLD after one cycle.
- SR_HOLD→SR_EXIT on a wake request.
- SR_EXIT→READY when the exit count ends.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: `sd_clk` is the system clock divided by CLK_DIV (default 4) with equal high and low phases. Bus outputs change only on the edge where `sd_clk` falls, so they are stable over the whole high phase.
- R2: While reset is held, `sd_cke` is 0, the command lines {cs_n,ras_n,cas_n,we_n} are 1111 (inhibit), address and bank are 0, and `init_done`, `ready` and `asleep` are 0.
- R3: After reset, the first INIT_LOW_CYC SDRAM cycles show `sd_cke`=0 with inhibit. The next INIT_HIGH_CYC cycles show `sd_cke`=1 with inhibit. Address and bank are 0 throughout both waits.
- R4: The next cycle carries PRECHARGE ALL, coded 0010. In that cycle address bit AP_BIT (default 10) is 1, every other address bit is 0, and bank is 0.
- R5: The next REFRESH_NUM (default 8) consecutive cycles each carry AUTO REFRESH, coded 0001, with address and bank at 0.
- R6: The next cycle carries LOAD MODE REGISTER, coded 0000, with address equal to MODE_WORD (default 0x23: CAS latency 2, sequential, burst 8) and bank 0.
- R7: SETTLE_CYC inhibit cycles follow. From the next cycle on, `init_done` and `ready` are 1, and `init_done` stays 1 until reset.
- R8: A `sleep_req` seen in READY makes the next SDRAM cycle carry AUTO REFRESH with `sd_cke`=0. Every following cycle shows inhibit with `sd_cke`=0, `asleep`=1 and `ready`=0.
- R9: A `wake_req` seen while asleep gives EXIT_CYC cycles with `sd_cke`=1, inhibit, and `ready`=`asleep`=0. `ready` returns to 1 on the cycle after those.
- R10: Sleep and wake requests before `init_done` have no effect. A wake request outside self-refresh has no effect, and neither does a sleep request during self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Request entry into self-refresh |
| wake_req | input | 1 | Request exit from self-refresh |
| sd_clk | output | 1 | SDRAM clock, system clock / CLK_DIV |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_BITS (12) | Address lines |
| sd_ba | output | BANK_BITS (2) | Bank select lines |
| init_done | output | 1 | Sticky: power-up sequence complete |
| ready | output | 1 | Device idle and awake |
| asleep | output | 1 | Device held in self-refresh |

## Verification
The bench builds the block with CLK_DIV=4, INIT_LOW_CYC=5, INIT_HIGH_CYC=30 (six times the first wait), SETTLE_CYC=2 and EXIT_CYC=3, keeping eight refreshes and the 0x23 mode word. These short waits make the entire power-up train fit in under fifty SDRAM cycles. The bench compares every one of those cycles against an arithmetic model of the expected sequence, and it injects requests mid-sequence to confirm they are ignored. Two full sleep/wake round trips then follow, including stray requests in each state and the exact length of the exit window.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        S_PWR_LOW,
        S_PWR_HIGH,
        S_PRE_ALL,
        S_AREF_RUN,
        S_LOAD_MODE,
        S_SETTLE,
        S_READY,
        S_SR_ENTER,
        S_SR_HOLD,
        S_SR_EXIT
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_INHIBIT = 4'b1111;
    localparam logic [3:0] CMD_PRE     = 4'b0010;
    localparam logic [3:0] CMD_AREF    = 4'b0001;
    localparam logic [3:0] CMD_LMR     = 4'b0000;

endpackage

// File: rtl/sdr_clk_gen.sv
module sdr_clk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic sd_clk,
    output logic tick
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] phase_q;
    logic [CW-1:0] phase_inc;
    logic          wrap;

    assign wrap      = (phase_q == CW'(DIV - 1));
    assign phase_inc = phase_q + CW'(1);
    assign tick      = wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            sd_clk  <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            sd_clk  <= 1'b0;
        end else begin
            phase_q <= phase_inc;
            sd_clk  <= (phase_inc >= CW'(HALF));
        end
    end

    // R1
    tick_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> sd_clk);

    // R1
    fall_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !sd_clk);

    // R1
    rise_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_clk) |-> (phase_q == CW'(HALF)));

endmodule

// File: rtl/sdr_span_ctr.sv
module sdr_span_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == (limit - W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (restart) begin
                cnt_q <= '0;
            end else if (!last) begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    // R3
    span_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

    // R3
    span_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(cnt_q));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdr_seq_pkg::*;
#(
    parameter int          CLK_DIV       = 4,
    parameter int          ROW_BITS      = 12,
    parameter int          BANK_BITS     = 2,
    parameter int          AP_BIT        = 10,
    parameter int unsigned MODE_WORD     = 'h23,
    parameter int          INIT_LOW_CYC  = 500,
    parameter int          INIT_HIGH_CYC = 3000,
    parameter int          REFRESH_NUM   = 8,
    parameter int          SETTLE_CYC    = 2,
    parameter int          EXIT_CYC      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 wake_req,
    output logic                 sd_clk,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [ROW_BITS-1:0]  sd_addr,
    output logic [BANK_BITS-1:0] sd_ba,
    output logic                 init_done,
    output logic                 ready,
    output logic                 asleep
);
    localparam int M1       = (INIT_LOW_CYC > INIT_HIGH_CYC) ? INIT_LOW_CYC : INIT_HIGH_CYC;
    localparam int M2       = (REFRESH_NUM > SETTLE_CYC) ? REFRESH_NUM : SETTLE_CYC;
    localparam int M3       = (M1 > M2) ? M1 : M2;
    localparam int SPAN_MAX = (M3 > EXIT_CYC) ? M3 : EXIT_CYC;
    localparam int CNT_W    = $clog2(SPAN_MAX + 1);

    localparam logic [ROW_BITS-1:0] AP_MASK  = ROW_BITS'(1) << AP_BIT;
    localparam logic [ROW_BITS-1:0] MODE_VAL = ROW_BITS'(MODE_WORD);

    seq_state_e          state_q, state_nx;
    logic                tick;
    logic                span_last;
    logic                span_restart;
    logic [CNT_W-1:0]    span_limit;
    logic [3:0]          cmd;
    logic                done_q;

    sdr_clk_gen #(.DIV(CLK_DIV)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sd_clk (sd_clk),
        .tick   (tick)
    );

    sdr_span_ctr #(.W(CNT_W)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (span_restart),
        .limit   (span_limit),
        .last    (span_last)
    );

    assign span_restart = (state_nx != state_q);

    // Length of each timed state in SDRAM cycles
    always_comb begin
        unique case (state_q)
            S_PWR_LOW:  span_limit = CNT_W'(INIT_LOW_CYC);
            S_PWR_HIGH: span_limit = CNT_W'(INIT_HIGH_CYC);
            S_AREF_RUN: span_limit = CNT_W'(REFRESH_NUM);
            S_SETTLE:   span_limit = CNT_W'(SETTLE_CYC);
            S_SR_EXIT:  span_limit = CNT_W'(EXIT_CYC);
            default:    span_limit = CNT_W'(1);
        endcase
    end

    // Transition logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_PWR_LOW:   if (span_last) state_nx = S_PWR_HIGH;
            S_PWR_HIGH:  if (span_last) state_nx = S_PRE_ALL;
            S_PRE_ALL:   state_nx = S_AREF_RUN;
            S_AREF_RUN:  if (span_last) state_nx = S_LOAD_MODE;
            S_LOAD_MODE: state_nx = S_SETTLE;
            S_SETTLE:    if (span_last) state_nx = S_READY;
            S_READY:     if (sleep_req) state_nx = S_SR_ENTER;
            S_SR_ENTER:  state_nx = S_SR_HOLD;
            S_SR_HOLD:   if (wake_req) state_nx = S_SR_EXIT;
            S_SR_EXIT:   if (span_last) state_nx = S_READY;
            default:     state_nx = S_PWR_LOW;
        endcase
    end

    // State register: advances once per SDRAM period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PWR_LOW;
            done_q  <= 1'b0;
        end else if (tick) begin
            state_q <= state_nx;
            if (state_q == S_SETTLE && span_last) begin
                done_q <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        sd_cke  = 1'b1;
        cmd     = CMD_INHIBIT;
        sd_addr = '0;
        sd_ba   = '0;
        unique case (state_q)
            S_PWR_LOW:   sd_cke = 1'b0;
            S_PWR_HIGH:  ;
            S_PRE_ALL: begin
                cmd     = CMD_PRE;
                sd_addr = AP_MASK;
            end
            S_AREF_RUN:  cmd = CMD_AREF;
            S_LOAD_MODE: begin
                cmd     = CMD_LMR;
                sd_addr = MODE_VAL;
            end
            S_SETTLE:    ;
            S_READY:     ;
            S_SR_ENTER: begin
                cmd    = CMD_AREF;
                sd_cke = 1'b0;
            end
            S_SR_HOLD:   sd_cke = 1'b0;
            S_SR_EXIT:   ;
            default:     ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign init_done = done_q;
    assign ready     = (state_q == S_READY);
    assign asleep    = (state_q == S_SR_HOLD);

    // R1
    cmd_on_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(cmd) && $stable(sd_cke) && $stable(sd_addr)));

    // R6
    lmr_after_aref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd == CMD_LMR) |-> ($past(cmd) == CMD_AREF));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    sr_entry_aref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (cmd == CMD_AREF));

    // R9
    cke_rise_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> (cmd == CMD_INHIBIT));

    // R10
    no_sleep_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> init_done);

endmodule

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;
    localparam int DIV   = 4;
    localparam int LOW   = 5;
    localparam int HIGH  = 30;
    localparam int NREF  = 8;
    localparam int SETL  = 2;
    localparam int EXITC = 3;
    localparam int MODEW = 'h23;
    localparam int P_PRE  = LOW + HIGH;
    localparam int P_LMR  = P_PRE + NREF + 1;
    localparam int P_RDY  = P_LMR + 1 + SETL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        sd_clk, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba;
    logic        init_done, ready, asleep;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_DIV(DIV), .ROW_BITS(12), .BANK_BITS(2), .AP_BIT(10),
        .MODE_WORD(MODEW), .INIT_LOW_CYC(LOW), .INIT_HIGH_CYC(HIGH),
        .REFRESH_NUM(NREF), .SETTLE_CYC(SETL), .EXIT_CYC(EXITC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .sd_clk(sd_clk), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .init_done(init_done), .ready(ready), .asleep(asleep)
    );

    function automatic logic [3:0] cmd_now();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Sample just after a rising SDRAM clock edge
    task automatic sample();
        @(posedge sd_clk);
        #1;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        sample();
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1;
        sample();
        wake_req = 1'b0;
    endtask

    task automatic check_bus(input string tag, input logic cke, input logic [3:0] c,
                             input logic rdy, input logic slp);
        check({tag, " cke"}, 32'(sd_cke), 32'(cke));
        check({tag, " cmd"}, 32'(cmd_now()), 32'(c));
        check({tag, " ready"}, 32'(ready), 32'(rdy));
        check({tag, " asleep"}, 32'(asleep), 32'(slp));
    endtask

    task automatic sleep_wake_round(input int hold);
        pulse_sleep();
        check_bus("R8 enter", 1'b0, 4'b0001, 1'b0, 1'b0);
        for (int i = 0; i < hold; i++) begin
            sample();
            check_bus("R8 hold", 1'b0, 4'b1111, 1'b0, 1'b1);
        end
        pulse_sleep();
        check_bus("R10 sleep while asleep", 1'b0, 4'b1111, 1'b0, 1'b1);
        pulse_wake();
        for (int i = 0; i < EXITC; i++) begin
            if (i > 0) sample();
            check_bus("R9 exit", 1'b1, 4'b1111, 1'b0, 1'b0);
        end
        sample();
        check_bus("R9 ready", 1'b1, 4'b1111, 1'b1, 1'b0);
        check("R7 done kept", 32'(init_done), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        realtime t_rise, t_fall, t_next;
        logic [3:0] c_a;
        logic       k_a;

        repeat (4) @(posedge clk);
        #2;
        // R2 reset state
        check("R2 cke", 32'(sd_cke), 32'd0);
        check("R2 cmd", 32'(cmd_now()), 32'hF);
        check("R2 addr", 32'(sd_addr), 32'd0);
        check("R2 ba", 32'(sd_ba), 32'd0);
        check("R2 done", 32'(init_done), 32'd0);
        check("R2 ready", 32'(ready), 32'd0);
        check("R2 asleep", 32'(asleep), 32'd0);
        check("R2 clk", 32'(sd_clk), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Whole power-up train, one check set per SDRAM cycle
        for (int k = 0; k <= P_RDY + 2; k++) begin
            logic       e_cke;
            logic [3:0] e_cmd;
            logic [11:0] e_addr;
            logic       e_done;
            sample();
            e_cke  = (k >= LOW);
            e_cmd  = 4'b1111;
            e_addr = 12'h000;
            e_done = (k >= P_RDY);
            if (k == P_PRE) begin
                e_cmd  = 4'b0010;
                e_addr = 12'h400;
            end else if (k > P_PRE && k < P_LMR) begin
                e_cmd = 4'b0001;
            end else if (k == P_LMR) begin
                e_cmd  = 4'b0000;
                e_addr = 12'(MODEW);
            end
            if (k < P_PRE) begin
                check($sformatf("R3 cke k=%0d", k), 32'(sd_cke), 32'(e_cke));
                check($sformatf("R3 cmd k=%0d", k), 32'(cmd_now()), 32'(e_cmd));
            end else if (k == P_PRE) begin
                check("R4 cmd", 32'(cmd_now()), 32'(e_cmd));
                check("R4 addr", 32'(sd_addr), 32'(e_addr));
            end else if (k < P_LMR) begin
                check($sformatf("R5 cmd k=%0d", k), 32'(cmd_now()), 32'(e_cmd));
            end else if (k == P_LMR) begin
                check("R6 cmd", 32'(cmd_now()), 32'(e_cmd));
                check("R6 addr", 32'(sd_addr), 32'(e_addr));
            end else begin
                check($sformatf("R7 cmd k=%0d", k), 32'(cmd_now()), 32'(e_cmd));
            end
            check($sformatf("R3 addr k=%0d", k), 32'(sd_addr), 32'(e_addr));
            check($sformatf("R3 ba k=%0d", k), 32'(sd_ba), 32'd0);
            check($sformatf("R7 done k=%0d", k), 32'(init_done), 32'(e_done));
            check($sformatf("R7 ready k=%0d", k), 32'(ready), 32'(e_done));
            check($sformatf("R10 asleep k=%0d", k), 32'(asleep), 32'd0);
            // R10: stray requests during power-up
            sleep_req = (k == 10 || k == P_LMR);
            wake_req  = (k == 20 || k == P_PRE + 2);
        end
        sleep_req = 1'b0;
        wake_req  = 1'b0;

        // R1: clock period, duty and output stability over the high phase
        @(posedge sd_clk);
        t_rise = $realtime;
        #1;
        c_a = cmd_now();
        k_a = sd_cke;
        @(negedge sd_clk);
        t_fall = $realtime;
        #0;
        check("R1 stable cmd", 32'(cmd_now()), 32'(c_a));
        check("R1 stable cke", 32'(sd_cke), 32'(k_a));
        @(posedge sd_clk);
        t_next = $realtime;
        check("R1 period ns", 32'(int'(t_next - t_rise)), 32'(DIV * 10));
        check("R1 high ns", 32'(int'(t_fall - t_rise)), 32'(DIV * 5));
        #1;

        // R10: wake while awake
        pulse_wake();
        check_bus("R10 wake while ready", 1'b1, 4'b1111, 1'b1, 1'b0);

        sleep_wake_round(1);
        sample();
        check_bus("R9 idle", 1'b1, 4'b1111, 1'b1, 1'b0);
        sleep_wake_round(4);

        summary();
        $finish;
    end
endmodule